// File: doc/BRIEF.md
# Flash Security Mode Guard

This block holds the security mode of an on-chip flash and decides, in the same cycle as each request, whether the request is allowed. There are three modes: Open, Locked and Sealed. The mode is held in a register. At reset it is loaded from a persistent value supplied on `boot_mode`, and it changes only through a mode-change request. Changes are one-way. Open may move to Locked or to Sealed. Locked may return to Open only after a full erase has been reported. Sealed can never be left.

The block filters three kinds of traffic. Debug-port accesses are allowed only in Open. External erase requests are allowed in Open and Locked, and refused in Sealed. Row reads and row writes are checked against a read-protect bit and a write-protect bit kept for each row. Those per-row bits apply in addition to the chip-level mode. A row request marked as coming from internal firmware through the system-call path is always granted.

The mode state machine has three states. The 2-bit encoding is Open = 00, Locked = 01 and Sealed = 11. It has these named transitions:
- LOCK (Open to Locked)
- SEAL (Open to Sealed)
- UNLOCK (Locked to Open, with an erase pending)
- REFUSE (any other request; the mode is kept and an error is pulsed)

Top module: `flash_guard`

## Requirements
- R1: At reset the mode loads from `boot_mode`. The encodings are 00 = Open, 01 = Locked and 11 = Sealed. The unused code 10 loads as Sealed, and `mode_o` then reads 11.
- R2: In Open, a request with target 01 is accepted (LOCK), and a request with target 11 or 10 is accepted as Sealed (SEAL). `mode_o` shows the new mode one cycle after the request.
- R3: In Locked, a request with target 00 is accepted (UNLOCK) only if an erase is pending. Without a pending erase the request is refused.
- R4: In Sealed, every request is refused and the mode never changes.
- R5: A refused request leaves the mode unchanged and raises `chg_err` for exactly one cycle, one cycle after the request. Refused requests are: any request in Sealed, Locked to any target other than 00, Locked to 00 with no erase pending, and Open to 00.
- R6: A debug request is granted only in Open. It is denied in Locked and in Sealed. The answer comes in the same cycle as the request.
- R7: An external erase request is granted in Open and in Locked, and denied in Sealed, in the same cycle.
- R8: A row read is denied when that row's read-protect bit is set, and a row write is denied when that row's write-protect bit is set. The answer comes in the same cycle. A mask write (`msk_we`) takes effect from the next cycle; an access in the same cycle still sees the old bits. All mask bits clear at reset.
- R9: A row request with `row_sys` high is always granted, whatever the mode and the masks.
- R10: `erase_done` sets the pending-erase flag. The flag clears when an UNLOCK uses it, and on any granted row write. If `erase_done` and a granted write arrive in the same cycle, the flag is set.
- R11: For each request kind, grant and deny are never high together. Both are low when there is no request of that kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_mode | input | 2 | Persistent mode value loaded at reset |
| chg_req | input | 1 | Mode-change request strobe |
| chg_target | input | 2 | Requested mode |
| erase_done | input | 1 | Full-erase-complete pulse |
| mode_o | output | 2 | Current mode |
| chg_err | output | 1 | One-cycle refusal flag |
| dbg_req | input | 1 | Debug-port access request |
| dbg_grant | output | 1 | Debug access allowed |
| dbg_deny | output | 1 | Debug access refused |
| ers_req | input | 1 | External erase request |
| ers_grant | output | 1 | External erase allowed |
| ers_deny | output | 1 | External erase refused |
| row_req | input | 1 | Row access request |
| row_we | input | 1 | 1 = write, 0 = read |
| row_sys | input | 1 | Request from the internal system-call path |
| row_idx | input | IW | Row index of the access |
| row_grant | output | 1 | Row access allowed |
| row_deny | output | 1 | Row access refused |
| msk_we | input | 1 | Row mask update strobe |
| msk_idx | input | IW | Row whose mask bits are updated |
| msk_rd | input | 1 | New read-protect bit |
| msk_wr | input | 1 | New write-protect bit |

## Verification
The assertions check, on every cycle:
- Sealed never changes.
- Locked reaches Open only when an erase was pending.
- A refusal never coincides with a mode change.
- Debug grants occur only in Open.
- Sealed always denies erase.
- System-path requests are always granted.
- Grant and deny are never both high.
- A granted write clears the pending erase.

Only the bench's scenarios can show the rest:
- The whole transition table, swept over every start code, target code and pending-erase state.
- The per-row mask results for every row.
- The one-cycle lag of mask updates.
- The cases where a pending erase is consumed by an UNLOCK or by a write, and the case where an erase arriving together with a write keeps the flag set.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

    typedef enum logic [1:0] {
        FG_OPEN   = 2'b00,
        FG_LOCKED = 2'b01,
        FG_SEALED = 2'b11
    } fg_mode_e;

    // Unused code 10 maps to the most restrictive mode.
    function automatic fg_mode_e fg_decode(input logic [1:0] raw);
        fg_mode_e m;
        case (raw)
            2'b00:   m = FG_OPEN;
            2'b01:   m = FG_LOCKED;
            default: m = FG_SEALED;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/flash_guard_mode_fsm.sv
module flash_guard_mode_fsm
    import flash_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] boot_mode,
    input  logic       chg_req,
    input  logic [1:0] chg_target,
    input  logic       erase_done,
    input  logic       wr_done,
    output fg_mode_e   mode,
    output logic       chg_err
);

    fg_mode_e mode_q, mode_n;
    logic     err_q, err_n;
    logic     armed_q, armed_n;
    fg_mode_e tgt;
    logic     unlock;

    assign tgt = fg_decode(chg_target);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= fg_decode(boot_mode);
            err_q   <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            mode_q  <= mode_n;
            err_q   <= err_n;
            armed_q <= armed_n;
        end
    end

    // Next-state and output decode
    always_comb begin
        mode_n = mode_q;
        err_n  = 1'b0;
        unlock = 1'b0;
        if (chg_req) begin
            unique case (mode_q)
                FG_OPEN: begin
                    if (tgt != FG_OPEN) mode_n = tgt;       // LOCK or SEAL
                    else                err_n  = 1'b1;      // REFUSE
                end
                FG_LOCKED: begin
                    if (tgt == FG_OPEN && armed_q) begin    // UNLOCK
                        mode_n = FG_OPEN;
                        unlock = 1'b1;
                    end else begin
                        err_n = 1'b1;                       // REFUSE
                    end
                end
                FG_SEALED: err_n = 1'b1;                    // REFUSE
            endcase
        end
        armed_n = armed_q;
        if (unlock || wr_done) armed_n = 1'b0;
        if (erase_done)        armed_n = 1'b1;
    end

    assign mode    = mode_q;
    assign chg_err = err_q;

    AST_SEALED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == FG_SEALED) |=> (mode_q == FG_SEALED)); // R4
    AST_UNLOCK_NEEDS_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_q) == FG_LOCKED && mode_q == FG_OPEN) |-> $past(armed_q)); // R3
    AST_REFUSE_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> $stable(mode_q)); // R5
    AST_WRITE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && !erase_done) |=> !armed_q); // R10

endmodule

// File: rtl/flash_guard_row_mask.sv
module flash_guard_row_mask #(
    parameter  int ROWS = 64,
    localparam int IW   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_we,
    input  logic [IW-1:0] set_idx,
    input  logic          set_rd,
    input  logic          set_wr,
    input  logic [IW-1:0] look_idx,
    output logic          rd_blk,
    output logic          wr_blk
);

    logic [ROWS-1:0] rd_bits;
    logic [ROWS-1:0] wr_bits;

    for (genvar g = 0; g < ROWS; g++) begin : g_row
        logic rd_b, wr_b;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rd_b <= 1'b0;
                wr_b <= 1'b0;
            end else if (set_we && set_idx == IW'(g)) begin
                rd_b <= set_rd;
                wr_b <= set_wr;
            end
        end
        assign rd_bits[g] = rd_b;
        assign wr_bits[g] = wr_b;
    end

    assign rd_blk = rd_bits[look_idx];
    assign wr_blk = wr_bits[look_idx];

endmodule

// File: rtl/flash_guard_gate.sv
module flash_guard_gate
    import flash_guard_pkg::*;
(
    input  fg_mode_e mode,
    input  logic     dbg_req,
    input  logic     ers_req,
    input  logic     row_req,
    input  logic     row_we,
    input  logic     row_sys,
    input  logic     rd_blk,
    input  logic     wr_blk,
    output logic     dbg_grant,
    output logic     dbg_deny,
    output logic     ers_grant,
    output logic     ers_deny,
    output logic     row_grant,
    output logic     row_deny
);

    logic dbg_ok, ers_ok, row_ok;

    always_comb begin
        unique case (mode)
            FG_OPEN:   begin dbg_ok = 1'b1; ers_ok = 1'b1; end
            FG_LOCKED: begin dbg_ok = 1'b0; ers_ok = 1'b1; end
            FG_SEALED: begin dbg_ok = 1'b0; ers_ok = 1'b0; end
        endcase
        row_ok = row_sys || (row_we ? !wr_blk : !rd_blk);
    end

    assign dbg_grant = dbg_req &  dbg_ok;
    assign dbg_deny  = dbg_req & ~dbg_ok;
    assign ers_grant = ers_req &  ers_ok;
    assign ers_deny  = ers_req & ~ers_ok;
    assign row_grant = row_req &  row_ok;
    assign row_deny  = row_req & ~row_ok;

endmodule

// File: rtl/flash_guard.sv
module flash_guard
    import flash_guard_pkg::*;
#(
    parameter  int ROWS = 64,
    localparam int IW   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    boot_mode,
    input  logic          chg_req,
    input  logic [1:0]    chg_target,
    input  logic          erase_done,
    output logic [1:0]    mode_o,
    output logic          chg_err,
    input  logic          dbg_req,
    output logic          dbg_grant,
    output logic          dbg_deny,
    input  logic          ers_req,
    output logic          ers_grant,
    output logic          ers_deny,
    input  logic          row_req,
    input  logic          row_we,
    input  logic          row_sys,
    input  logic [IW-1:0] row_idx,
    output logic          row_grant,
    output logic          row_deny,
    input  logic          msk_we,
    input  logic [IW-1:0] msk_idx,
    input  logic          msk_rd,
    input  logic          msk_wr
);

    fg_mode_e mode;
    logic     rd_blk, wr_blk;
    logic     wr_done;

    assign wr_done = row_grant & row_we;

    flash_guard_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .boot_mode  (boot_mode),
        .chg_req    (chg_req),
        .chg_target (chg_target),
        .erase_done (erase_done),
        .wr_done    (wr_done),
        .mode       (mode),
        .chg_err    (chg_err)
    );

    flash_guard_row_mask #(.ROWS(ROWS)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_we   (msk_we),
        .set_idx  (msk_idx),
        .set_rd   (msk_rd),
        .set_wr   (msk_wr),
        .look_idx (row_idx),
        .rd_blk   (rd_blk),
        .wr_blk   (wr_blk)
    );

    flash_guard_gate u_gate (
        .mode      (mode),
        .dbg_req   (dbg_req),
        .ers_req   (ers_req),
        .row_req   (row_req),
        .row_we    (row_we),
        .row_sys   (row_sys),
        .rd_blk    (rd_blk),
        .wr_blk    (wr_blk),
        .dbg_grant (dbg_grant),
        .dbg_deny  (dbg_deny),
        .ers_grant (ers_grant),
        .ers_deny  (ers_deny),
        .row_grant (row_grant),
        .row_deny  (row_deny)
    );

    assign mode_o = mode;

    AST_DBG_ONLY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_grant |-> (mode_o == 2'b00)); // R6
    AST_SEALED_NO_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        (ers_req && mode_o == 2'b11) |-> ers_deny); // R7
    AST_SYS_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (row_req && row_sys) |-> row_grant); // R9
    AST_GRANT_DENY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(dbg_grant && dbg_deny) && !(ers_grant && ers_deny) && !(row_grant && row_deny)); // R11

endmodule

// File: tb/sim_flash_guard.sv
module sim_flash_guard;

    localparam int CLK_PERIOD = 10;
    localparam int ROWS = 64;
    localparam int IW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] boot_mode = 2'b00;
    logic chg_req = 0;
    logic [1:0] chg_target = 0;
    logic erase_done = 0;
    logic [1:0] mode_o;
    logic chg_err;
    logic dbg_req = 0, dbg_grant, dbg_deny;
    logic ers_req = 0, ers_grant, ers_deny;
    logic row_req = 0, row_we = 0, row_sys = 0;
    logic [IW-1:0] row_idx = 0;
    logic row_grant, row_deny;
    logic msk_we = 0;
    logic [IW-1:0] msk_idx = 0;
    logic msk_rd = 0, msk_wr = 0;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_guard #(.ROWS(ROWS)) u0 (
        .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode),
        .chg_req(chg_req), .chg_target(chg_target), .erase_done(erase_done),
        .mode_o(mode_o), .chg_err(chg_err),
        .dbg_req(dbg_req), .dbg_grant(dbg_grant), .dbg_deny(dbg_deny),
        .ers_req(ers_req), .ers_grant(ers_grant), .ers_deny(ers_deny),
        .row_req(row_req), .row_we(row_we), .row_sys(row_sys), .row_idx(row_idx),
        .row_grant(row_grant), .row_deny(row_deny),
        .msk_we(msk_we), .msk_idx(msk_idx), .msk_rd(msk_rd), .msk_wr(msk_wr)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int dec(input int raw);
        return (raw == 0) ? 0 : (raw == 1) ? 1 : 3;
    endfunction

    task automatic do_reset(input int b);
        @(negedge clk);
        rst_n = 0; boot_mode = 2'(b);
        chg_req = 0; erase_done = 0; dbg_req = 0; ers_req = 0;
        row_req = 0; row_we = 0; row_sys = 0; msk_we = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic pulse_erase();
        @(negedge clk); erase_done = 1;
        @(negedge clk); erase_done = 0;
    endtask

    // Request, then sample one cycle later: returns mode and error
    task automatic request(input int t, output int m, output int e);
        @(negedge clk); chg_req = 1; chg_target = 2'(t);
        @(negedge clk); chg_req = 0;
        m = int'(mode_o); e = int'(chg_err);
    endtask

    task automatic row_write(input int idx);
        @(negedge clk); row_req = 1; row_we = 1; row_sys = 0; row_idx = IW'(idx);
        @(negedge clk); row_req = 0; row_we = 0;
    endtask

    function automatic bit mrd(input int i); return (i % 3) == 0; endfunction
    function automatic bit mwr(input int i); return (i % 4) == 1; endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_err++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int m, e, s, em, ee;
        string tag;

        // Transition sweep over boot code, pending erase and target
        for (int b = 0; b < 4; b++) begin
            for (int a = 0; a < 2; a++) begin
                for (int t = 0; t < 4; t++) begin
                    do_reset(b);
                    #1;
                    chk("R1 reset mode", int'(mode_o), dec(b));
                    chk("R11 idle no grant/deny", int'({dbg_grant, dbg_deny, ers_grant, ers_deny, row_grant, row_deny}), 0);
                    if (a == 1) pulse_erase();
                    s = dec(b);
                    if (s == 0) begin
                        if (t != 0) begin em = dec(t); ee = 0; tag = "R2"; end
                        else begin em = 0; ee = 1; tag = "R5"; end
                    end else if (s == 1) begin
                        if (t == 0 && a == 1) begin em = 0; ee = 0; tag = "R3"; end
                        else begin em = 1; ee = 1; tag = (t == 0) ? "R3" : "R5"; end
                    end else begin
                        em = 3; ee = 1; tag = "R4";
                    end
                    request(t, m, e);
                    chk({tag, " mode"}, m, em);
                    chk({tag, " err"}, e, ee);
                    @(negedge clk);
                    chk("R5 err one cycle", int'(chg_err), 0);
                    chk("R5 mode held", int'(mode_o), em);
                    dbg_req = 1; ers_req = 1; #1;
                    chk("R6 dbg grant", int'(dbg_grant), (em == 0) ? 1 : 0);
                    chk("R6 dbg deny", int'(dbg_deny), (em == 0) ? 0 : 1);
                    chk("R7 erase grant", int'(ers_grant), (em == 3) ? 0 : 1);
                    chk("R7 erase deny", int'(ers_deny), (em == 3) ? 1 : 0);
                    @(negedge clk); dbg_req = 0; ers_req = 0;
                end
            end
        end

        // Sealed: every target refused repeatedly
        do_reset(3);
        for (int t = 0; t < 4; t++) begin
            request(t, m, e);
            chk("R4 sealed stays", m, 3);
            chk("R4 sealed err", e, 1);
        end

        // Pending erase consumed by UNLOCK
        do_reset(1);
        pulse_erase();
        request(0, m, e); chk("R10 unlock ok", m, 0);
        request(1, m, e); chk("R10 relock", m, 1);
        request(0, m, e);
        chk("R10 consumed mode", m, 1);
        chk("R10 consumed err", e, 1);

        // Pending erase cleared by a granted write
        do_reset(1);
        pulse_erase();
        row_write(5);
        request(0, m, e);
        chk("R10 write clears mode", m, 1);
        chk("R10 write clears err", e, 1);

        // Erase and granted write together: flag stays set
        do_reset(1);
        @(negedge clk); erase_done = 1; row_req = 1; row_we = 1; row_idx = 7;
        @(negedge clk); erase_done = 0; row_req = 0; row_we = 0;
        request(0, m, e);
        chk("R10 set wins mode", m, 0);
        chk("R10 set wins err", e, 0);

        // Mask update lag
        do_reset(0);
        @(negedge clk);
        msk_we = 1; msk_idx = 2; msk_rd = 1; msk_wr = 0;
        row_req = 1; row_we = 0; row_sys = 0; row_idx = 2; #1;
        chk("R8 old mask same cycle", int'(row_grant), 1);
        @(negedge clk); msk_we = 0; #1;
        chk("R8 new mask next cycle", int'(row_deny), 1);
        @(negedge clk); row_req = 0;

        // Program every row's masks
        do_reset(0);
        for (int i = 0; i < ROWS; i++) begin
            @(negedge clk);
            msk_we = 1; msk_idx = IW'(i); msk_rd = mrd(i); msk_wr = mwr(i);
        end
        @(negedge clk); msk_we = 0;

        // Row sweep: every row, read/write, normal/system path
        for (int i = 0; i < ROWS; i++) begin
            for (int w = 0; w < 2; w++) begin
                for (int sy = 0; sy < 2; sy++) begin
                    int expg;
                    @(negedge clk);
                    row_req = 1; row_we = w[0]; row_sys = sy[0]; row_idx = IW'(i); #1;
                    if (sy == 1) expg = 1;
                    else if (w == 1) expg = mwr(i) ? 0 : 1;
                    else expg = mrd(i) ? 0 : 1;
                    chk((sy == 1) ? "R9 sys grant" : "R8 row grant", int'(row_grant), expg);
                    chk("R11 row deny", int'(row_deny), 1 - expg);
                end
            end
        end
        @(negedge clk); row_req = 0; row_we = 0; row_sys = 0;

        // System path still granted in Sealed with masks blocking
        do_reset(3);
        @(negedge clk); msk_we = 1; msk_idx = 9; msk_rd = 1; msk_wr = 1;
        @(negedge clk); msk_we = 0;
        row_req = 1; row_we = 1; row_sys = 1; row_idx = 9; #1;
        chk("R9 sys in sealed", int'(row_grant), 1);
        row_sys = 0; #1;
        chk("R8 masked write", int'(row_deny), 1);
        @(negedge clk); row_req = 0; row_we = 0;

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule